// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Supervisor

This block sits in the digital part of a frequency synthesizer loop. It takes two pulse trains: a reference train and the VCO output after the programmable divider. Both arrive asynchronously to the block's system clock. A rising edge on the reference arms an "up" flop and a rising edge on the divided train arms a "down" flop. When both are armed, the pair clears. The block presents the result in two forms. The first is a single-ended pump control that drives high, drives low, or floats, given as a drive-enable plus a level for a three-state pad. The second is the raw up/down pair for a differential filter.

A supervisor measures, in every reference period, how many system clocks the correction pulse was active. A run of consecutive periods with a small phase error declares lock. A single period with a wide error drops lock. Dropping lock raises a sticky alarm for the controller and cuts the transmit-excitation enable. The enable is otherwise the transmit request qualified by lock.

Top module: `pfd_lock_top`

## Requirements
- R1: While rst_n is low, and after reset until an input edge arrives, all of the following are 0: up, down, pump_drive, locked, alarm and excite_en.
- R2: A reference rising edge asserts up 3 system clocks after it is driven: two synchronizer stages, then the flop. Up then stays high until a divided rising edge has passed the same path. While up is high, pump_drive=1 and pump_level=1.
- R3: A divided-input rising edge that leads the reference asserts down with the same 3-clock latency. While down is high, pump_drive=1 and pump_level=0.
- R4: Up and down are never high in the same cycle. When both edges are detected in the same cycle, neither asserts and pump_drive stays 0, which means the pump floats.
- R5: At each detected reference edge, the supervisor takes the number of clocks in which up or down was high since the previous reference edge. A count of at most 2 is a good period. locked rises at the evaluation of the 8th consecutive good period and not before.
- R6: A period whose count exceeds 2 clears locked at the reference edge that closes it and restarts the good-period run from zero. A wide pulse does not change locked before that edge.
- R7: alarm sets when locked falls and stays at 1 through later re-lock until alarm_clr is high for a cycle. A loss in the same cycle as a clear wins.
- R8: excite_en is 1 exactly when tx_req is 1 and locked is 1.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse train, asynchronous |
| div_in | input | 1 | Divided VCO pulse train, asynchronous |
| tx_req | input | 1 | Transmit request from the controller |
| alarm_clr | input | 1 | Clears the sticky loss-of-lock alarm |
| up | output | 1 | Correction pulse: reference leads |
| down | output | 1 | Correction pulse: divided leads |
| pump_drive | output | 1 | Three-state enable of the single-ended pump |
| pump_level | output | 1 | Pump level when driven (1 high, 0 low) |
| locked | output | 1 | Lock indication |
| alarm | output | 1 | Sticky loss-of-lock alarm |
| excite_en | output | 1 | Transmit-excitation enable |

## Verification
The hardest state to reach is a loss of lock and the alarm behaviour around it. Lock needs eight clean reference periods in a row. The loss is only evaluated at the reference edge after the wide pulse. The bench therefore drives whole reference/divided periods with a chosen edge offset in clocks. It builds lock with offsets of 0 and 2, then inserts one period with offset 3. It checks that locked holds until the next reference edge and then falls. It then re-locks and clears the alarm to show the alarm is sticky.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  typedef enum logic [1:0] {
    PUMP_FLOAT = 2'b00,
    PUMP_HIGH  = 2'b11,
    PUMP_LOW   = 2'b10
  } pump_state_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d[0] = async_in;
    for (int i = 1; i <= STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_rise,
  input  logic        div_rise,
  output logic        up_q,
  output logic        dn_q,
  output pump_state_e pump
);
  logic up_d, dn_d, up_arm, dn_arm;

  always_comb begin
    up_arm = up_q | ref_rise;
    dn_arm = dn_q | div_rise;
    up_d   = up_arm & ~dn_arm;
    dn_d   = dn_arm & ~up_arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  always_comb begin
    if (up_q)      pump = PUMP_HIGH;
    else if (dn_q) pump = PUMP_LOW;
    else           pump = PUMP_FLOAT;
  end

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));
  a_r2_up_from_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(ref_rise));
  a_r3_dn_from_div: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> $past(div_rise));
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int ERR_MAX      = 2,
  parameter int LOCK_PERIODS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic active,
  input  logic alarm_clr,
  output logic lock_q,
  output logic alarm_q
);
  localparam int EW = $clog2(ERR_MAX + 2) + 1;
  localparam int LW = $clog2(LOCK_PERIODS + 1) + 1;
  localparam logic [EW-1:0] ERR_SAT = EW'(ERR_MAX + 1);
  localparam logic [LW-1:0] RUN_TOP = LW'(LOCK_PERIODS);

  logic [EW-1:0] err_q, err_d, err_sum;
  logic [LW-1:0] run_q, run_d, run_inc;
  logic          lock_d, alarm_d, good, drop;

  always_comb begin
    err_sum = (err_q >= ERR_SAT) ? ERR_SAT : err_q + EW'(active);
    good    = err_sum <= EW'(ERR_MAX);
    run_inc = (run_q >= RUN_TOP) ? RUN_TOP : run_q + LW'(1);
    err_d   = err_q;
    run_d   = run_q;
    lock_d  = lock_q;
    if (ref_rise) begin
      err_d = '0;
      if (good) begin
        run_d  = run_inc;
        lock_d = (run_inc >= RUN_TOP);
      end else begin
        run_d  = '0;
        lock_d = 1'b0;
      end
    end else begin
      err_d = err_sum;
    end
    drop    = lock_q & ~lock_d;
    alarm_d = drop | (alarm_q & ~alarm_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      run_q   <= '0;
      lock_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      err_q   <= err_d;
      run_q   <= run_d;
      lock_q  <= lock_d;
      alarm_q <= alarm_d;
    end
  end

  a_r5_lock_at_ref_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(ref_rise));
  a_r6_unlock_at_ref_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(ref_rise));
  a_r7_alarm_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> alarm_q);
  a_r7_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alarm_q) && !$past(alarm_clr)) |-> alarm_q);
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_lock_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ERR_MAX      = 2,
  parameter int LOCK_PERIODS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic div_in,
  input  logic tx_req,
  input  logic alarm_clr,
  output logic up,
  output logic down,
  output logic pump_drive,
  output logic pump_level,
  output logic locked,
  output logic alarm,
  output logic excite_en
);
  logic [1:0]  rises;
  logic [1:0]  raw_in;
  pump_state_e pump;

  assign raw_in = {div_in, ref_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_in[g]),
      .rise     (rises[g])
    );
  end

  pfd_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (rises[0]),
    .div_rise (rises[1]),
    .up_q     (up),
    .dn_q     (down),
    .pump     (pump)
  );

  pfd_lock_mon #(.ERR_MAX(ERR_MAX), .LOCK_PERIODS(LOCK_PERIODS)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_rise  (rises[0]),
    .active    (up | down),
    .alarm_clr (alarm_clr),
    .lock_q    (locked),
    .alarm_q   (alarm)
  );

  assign pump_drive = pump[1];
  assign pump_level = pump[0];
  assign excite_en  = tx_req & locked;

  a_r3_low_means_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_drive && !pump_level) |-> down);
  a_r8_no_excite_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !excite_en);
endmodule

// File: tb/pfd_lock_top_bench.sv
`timescale 1ns/1ps
module pfd_lock_top_bench;
  logic clk = 1'b0;
  logic rst_n, ref_in, div_in, tx_req, alarm_clr;
  logic up, down, pump_drive, pump_level, locked, alarm, excite_en;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pfd_lock_top u_pfd_lock_top (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in),
    .tx_req(tx_req), .alarm_clr(alarm_clr), .up(up), .down(down),
    .pump_drive(pump_drive), .pump_level(pump_level), .locked(locked),
    .alarm(alarm), .excite_en(excite_en)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    ref_in = 0; div_in = 0; tx_req = 0; alarm_clr = 0; rst_n = 0;
    cycles(3);
    rst_n = 1;
    cycles(2);
  endtask

  // one 16-clock period; lagging edge follows leading edge by off clocks
  task automatic period(input int off, input bit ref_leads);
    if (off == 0) begin ref_in = 1; div_in = 1; end
    else if (ref_leads) ref_in = 1; else div_in = 1;
    cycles(off);
    ref_in = 1; div_in = 1;
    cycles(8 - off);
    ref_in = 0; div_in = 0;
    cycles(8);
  endtask

  task automatic t_reset();
    rst_n = 0; ref_in = 0; div_in = 0; tx_req = 1; alarm_clr = 0;
    cycles(2);
    check("R1", "up in reset", up, 0);
    check("R1", "down in reset", down, 0);
    check("R1", "pump_drive in reset", pump_drive, 0);
    check("R1", "locked in reset", locked, 0);
    check("R1", "alarm in reset", alarm, 0);
    check("R1", "excite_en in reset", excite_en, 0);
    rst_n = 1; tx_req = 0;
    cycles(4);
    check("R1", "up idle after reset", up, 0);
  endtask

  task automatic t_ref_leads();
    do_reset();
    ref_in = 1;
    cycles(2);
    check("R2", "up not yet at 2 clocks", up, 0);
    cycles(1);
    check("R2", "up at 3 clocks", up, 1);
    check("R2", "pump_drive while up", pump_drive, 1);
    check("R2", "pump_level high", pump_level, 1);
    div_in = 1;
    cycles(2);
    check("R2", "up held until div edge passes", up, 1);
    cycles(1);
    check("R2", "up cleared by div edge", up, 0);
    check("R2", "pump floats after", pump_drive, 0);
    ref_in = 0; div_in = 0;
    cycles(4);
  endtask

  task automatic t_div_leads();
    do_reset();
    div_in = 1;
    cycles(3);
    check("R3", "down asserted", down, 1);
    check("R3", "up stays low", up, 0);
    check("R3", "pump_drive while down", pump_drive, 1);
    check("R3", "pump_level low", pump_level, 0);
    ref_in = 1;
    cycles(3);
    check("R3", "down cleared", down, 0);
    ref_in = 0; div_in = 0;
    cycles(4);
  endtask

  task automatic t_coincident();
    int seen;
    do_reset();
    seen = 0;
    ref_in = 1; div_in = 1;
    for (int i = 0; i < 12; i++) begin
      cycles(1);
      if (pump_drive || up || down) seen++;
    end
    check("R4", "no pulse on coincident edges", seen != 0, 0);
    ref_in = 0; div_in = 0;
    cycles(4);
  endtask

  task automatic t_lock_loss();
    do_reset();
    tx_req = 1;
    for (int i = 0; i < 7; i++) period((i % 2 == 0) ? 2 : 0, (i % 3) != 1);
    check("R5", "not locked after 7 good periods", locked, 0);
    check("R8", "excite off while unlocked", excite_en, 0);
    period(2, 1);
    check("R5", "locked after 8 good periods", locked, 1);
    check("R8", "excite on when locked and requested", excite_en, 1);
    tx_req = 0;
    cycles(1);
    check("R8", "excite off without request", excite_en, 0);
    tx_req = 1;
    period(3, 1);
    check("R6", "lock held until closing ref edge", locked, 1);
    check("R7", "no alarm yet", alarm, 0);
    period(0, 1);
    check("R6", "lock lost on wide period", locked, 0);
    check("R7", "alarm set on loss", alarm, 1);
    check("R8", "excite cut on loss", excite_en, 0);
    for (int i = 0; i < 7; i++) period(1, 0);
    check("R6", "run restarted: not locked after 7", locked, 0);
    period(1, 0);
    check("R5", "re-locked", locked, 1);
    check("R7", "alarm still held after re-lock", alarm, 1);
    alarm_clr = 1;
    cycles(1);
    alarm_clr = 0;
    cycles(1);
    check("R7", "alarm cleared", alarm, 0);
    check("R7", "clear leaves lock", locked, 1);
    tx_req = 0;
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ref_leads();
    t_div_leads();
    t_coincident();
    t_lock_loss();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule